// File: doc/BRIEF.md
# Lock-Aware Way Replacement Selector

This block chooses which way of a set-associative tag store receives a new line. Ways can be pinned by lock requests. Every requester owns a way mask, and only the ways inside that mask are candidates for that requester. A request arrives with:

- a requester number,
- an index,
- a kind: a plain miss, or a fill that also asks to lock the line.

The block keeps one lock bit per index and way, plus one rotating pointer per index. It answers with the way that was chosen.

Two misuse cases raise sticky flags, and each flag drives its own maskable interrupt:

- A lock request that would pin the last unlocked way visible to the requester is refused.
- A miss that finds every permitted way locked takes the lowest permitted way and unlocks it.

The block does not store tags, detect hits or hold data. It only does victim choice and lock bookkeeping.

Top module: `lockrep_sel`

## Requirements
- R1: After reset `rsp_valid`, both error flags and both interrupts are 0, every lock bit is clear and every per-index pointer is 0.
- R2: The mask of requester r is `way_masks[r*WAYS +: WAYS]`, and bit w set means way w is permitted. When the mask contains at least one unlocked way, the reported way is one of those unlocked permitted ways.
- R3: Among the unlocked permitted ways, the victim is the first one found by scanning upward from the index's pointer and wrapping past the top way. After every request with a non-empty mask, that index's pointer becomes victim+1, modulo WAYS. Each index has its own pointer.
- R4: `req_lock`=1 marks a lock request, and 0 marks a plain miss. A lock request chooses its way exactly as a miss does. It sets that way's lock bit only when at least two permitted ways were unlocked before the request.
- R5: A lock request that finds exactly one unlocked permitted way still reports that way. It leaves the way unlocked and sets `err_lock`.
- R6: When no permitted way is unlocked, the lowest-numbered permitted way is reported, its lock bit is cleared and `err_evict` is set. A lock request in this situation is also refused and sets `err_lock` as well.
- R7: A request whose mask is empty reports way 0. It changes no lock bit, no pointer and no flag.
- R8: Both flags are sticky. Writing 1 to `flag_clr` bit 0 clears `err_lock`, and writing 1 to bit 1 clears `err_evict`. When a set and a clear of the same flag fall in the same cycle, the set wins.
- R9: `irq_lock` equals `err_lock` AND `irq_en_lock`, and `irq_evict` equals `err_evict` AND `irq_en_evict`. Both are combinational from the flag and the enable.
- R10: One request is accepted per cycle. `rsp_valid` and `rsp_way` are registered and appear on the cycle after the request. The flags update on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_lock | input | 1 | 1 = lock fill, 0 = plain miss |
| req_id | input | $clog2(REQS) | Requester number |
| req_index | input | IDX_W | Set index |
| way_masks | input | REQS*WAYS | Per-requester permitted-way masks |
| flag_clr | input | 2 | Write-1-to-clear: bit 0 lock flag, bit 1 evict flag |
| irq_en_lock | input | 1 | Interrupt enable for the lock flag |
| irq_en_evict | input | 1 | Interrupt enable for the evict flag |
| rsp_valid | output | 1 | Response valid |
| rsp_way | output | $clog2(WAYS) | Chosen way |
| err_lock | output | 1 | Sticky refused-lock flag |
| err_evict | output | 1 | Sticky forced-eviction flag |
| irq_lock | output | 1 | Gated lock-flag interrupt |
| irq_evict | output | 1 | Gated evict-flag interrupt |

## Verification
The risky overlap is a flag being raised by a request in the same cycle that the write-1 clear of that flag arrives. The bench provokes it by issuing a refused lock request while `flag_clr` bit 0 is held high on that edge. It judges the outcome by requiring `err_lock` to read 1 afterwards. A second overlap is the two errors firing together: a lock request whose mask has every way locked must raise both flags in one cycle, and must leave the forced way unlocked.

// File: rtl/lockrep_pkg.sv
package lockrep_pkg;
   localparam int FLAG_LOCK  = 0;
   localparam int FLAG_EVICT = 1;
   localparam int NUM_FLAGS  = 2;

   typedef enum logic {
      OP_MISS = 1'b0,
      OP_LOCK = 1'b1
   } op_e;
endpackage

// File: rtl/lockrep_pick.sv
// Circular first-set finder: lowest offset from 'start' among set bits of 'cand'.
module lockrep_pick #(
   parameter int WAYS  = 8,
   parameter int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  cand,
   input  logic [WAY_W-1:0] start,
   output logic [WAY_W-1:0] way,
   output logic             found
);
   logic [WAY_W-1:0] pos;

   always_comb begin
      way   = '0;
      found = 1'b0;
      pos   = '0;
      for (int k = WAYS - 1; k >= 0; k--) begin
         pos = start + WAY_W'(k);
         if (cand[pos]) begin
            way   = pos;
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/lockrep_store.sv
// Per-index lock vectors and rotating pointers.
module lockrep_store #(
   parameter int WAYS  = 8,
   parameter int IDX_W = 4,
   parameter int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             we,
   input  logic [WAYS-1:0]  lock_wr,
   input  logic [WAY_W-1:0] ptr_wr,
   output logic [WAYS-1:0]  lock_rd,
   output logic [WAY_W-1:0] ptr_rd
);
   localparam int SETS = 1 << IDX_W;

   logic [WAYS-1:0]  lock_q [SETS];
   logic [WAY_W-1:0] ptr_q  [SETS];

   genvar s;
   generate
      for (s = 0; s < SETS; s++) begin : g_set
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lock_q[s] <= '0;
               ptr_q[s]  <= '0;
            end else if (we && idx == IDX_W'(s)) begin
               lock_q[s] <= lock_wr;
               ptr_q[s]  <= ptr_wr;
            end
         end
      end
   endgenerate

   assign lock_rd = lock_q[idx];
   assign ptr_rd  = ptr_q[idx];
endmodule

// File: rtl/lockrep_flag.sv
// Sticky error flag; a set in the same cycle as a clear wins.
module lockrep_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic irq_en,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   assign irq = flag & irq_en;
endmodule

// File: rtl/lockrep_sel.sv
module lockrep_sel
   import lockrep_pkg::*;
#(
   parameter int WAYS  = 8,
   parameter int REQS  = 4,
   parameter int IDX_W = 4,
   localparam int WAY_W = $clog2(WAYS),
   localparam int RID_W = (REQS > 1) ? $clog2(REQS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_lock,
   input  logic [RID_W-1:0]     req_id,
   input  logic [IDX_W-1:0]     req_index,
   input  logic [REQS*WAYS-1:0] way_masks,
   input  logic [1:0]           flag_clr,
   input  logic                 irq_en_lock,
   input  logic                 irq_en_evict,
   output logic                 rsp_valid,
   output logic [WAY_W-1:0]     rsp_way,
   output logic                 err_lock,
   output logic                 err_evict,
   output logic                 irq_lock,
   output logic                 irq_evict
);
   generate
      if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
         $error("WAYS must be a power of two, at least 2");
      end
      if (REQS < 1) begin : g_bad_reqs
         $error("REQS must be at least 1");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("IDX_W must be at least 1");
      end
   endgenerate

   op_e              op;
   logic [WAYS-1:0]  mask, lk, cand, lk_next;
   logic [WAY_W-1:0] ptr, rr_way, low_way, victim;
   logic             rr_found, low_found, forced, lock_ok, refuse, we;
   logic [NUM_FLAGS-1:0] fset, fval, firq, fen;

   assign op   = op_e'(req_lock);
   assign mask = way_masks[req_id*WAYS +: WAYS];
   assign cand = mask & ~lk;

   lockrep_store #(.WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (req_index),
      .we      (we),
      .lock_wr (lk_next),
      .ptr_wr  (victim + WAY_W'(1)),
      .lock_rd (lk),
      .ptr_rd  (ptr)
   );

   lockrep_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_rr_pick (
      .cand  (cand),
      .start (ptr),
      .way   (rr_way),
      .found (rr_found)
   );

   lockrep_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_low_pick (
      .cand  (mask),
      .start ('0),
      .way   (low_way),
      .found (low_found)
   );

   always_comb begin
      victim  = rr_found ? rr_way : low_way;
      forced  = low_found && !rr_found;
      lock_ok = (op == OP_LOCK) && ($countones(cand) >= 2);
      refuse  = (op == OP_LOCK) && low_found && !lock_ok;
      we      = req_valid && low_found;
      lk_next = lk;
      if (forced)  lk_next[victim] = 1'b0;
      if (lock_ok) lk_next[victim] = 1'b1;
   end

   assign fset[FLAG_LOCK]  = req_valid && refuse;
   assign fset[FLAG_EVICT] = req_valid && forced;
   assign fen[FLAG_LOCK]   = irq_en_lock;
   assign fen[FLAG_EVICT]  = irq_en_evict;

   genvar f;
   generate
      for (f = 0; f < NUM_FLAGS; f++) begin : g_flag
         lockrep_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set    (fset[f]),
            .clr    (flag_clr[f]),
            .irq_en (fen[f]),
            .flag   (fval[f]),
            .irq    (firq[f])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_way   <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) rsp_way <= low_found ? victim : '0;
      end
   end

   assign err_lock  = fval[FLAG_LOCK];
   assign err_evict = fval[FLAG_EVICT];
   assign irq_lock  = firq[FLAG_LOCK];
   assign irq_evict = firq[FLAG_EVICT];
endmodule

// File: rtl/lockrep_sel_chk.sv
module lockrep_sel_chk #(
   parameter int WAYS  = 8,
   parameter int REQS  = 4,
   parameter int WAY_W = $clog2(WAYS),
   parameter int RID_W = (REQS > 1) ? $clog2(REQS) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_lock,
   input logic [RID_W-1:0]     req_id,
   input logic [REQS*WAYS-1:0] way_masks,
   input logic [1:0]           flag_clr,
   input logic                 irq_en_lock,
   input logic                 irq_en_evict,
   input logic                 rsp_valid,
   input logic [WAY_W-1:0]     rsp_way,
   input logic                 err_lock,
   input logic                 err_evict,
   input logic                 irq_lock,
   input logic                 irq_evict
);
   logic [WAYS-1:0] chk_mask;
   assign chk_mask = way_masks[req_id*WAYS +: WAYS];

   p_rsp_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   p_way_in_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_valid) && ($past(chk_mask) != '0))
      |-> ((($past(chk_mask) >> rsp_way) & WAYS'(1)) != '0));
   p_empty_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && chk_mask == '0) |=>
      (rsp_way == '0) && !$rose(err_lock) && !$rose(err_evict));
   p_lock_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_lock) |-> $past(req_valid && req_lock));
   p_evict_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_evict) |-> $past(req_valid));
   p_sticky_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_lock && !flag_clr[0]) |=> err_lock);
   p_sticky_evict_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_evict && !flag_clr[1]) |=> err_evict);
   p_irq_lock_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_lock |-> !irq_lock);
   p_irq_evict_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_evict |-> !irq_evict);
endmodule

bind lockrep_sel lockrep_sel_chk #(.WAYS(WAYS), .REQS(REQS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_lock     (req_lock),
   .req_id       (req_id),
   .way_masks    (way_masks),
   .flag_clr     (flag_clr),
   .irq_en_lock  (irq_en_lock),
   .irq_en_evict (irq_en_evict),
   .rsp_valid    (rsp_valid),
   .rsp_way      (rsp_way),
   .err_lock     (err_lock),
   .err_evict    (err_evict),
   .irq_lock     (irq_lock),
   .irq_evict    (irq_evict)
);

// File: tb/lockrep_sel_bench.sv
`timescale 1ns/1ps
module lockrep_sel_bench;
   localparam int WAYS = 8, REQS = 4, IDX_W = 4;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 req_valid = 1'b0, req_lock = 1'b0;
   logic [1:0]           req_id = '0;
   logic [IDX_W-1:0]     req_index = '0;
   logic [REQS*WAYS-1:0] way_masks = {8'h00, 8'hF0, 8'h03, 8'hFF};
   logic [1:0]           flag_clr = '0;
   logic                 irq_en_lock = 1'b1, irq_en_evict = 1'b0;
   logic                 rsp_valid, err_lock, err_evict, irq_lock, irq_evict;
   logic [2:0]           rsp_way;

   int n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   lockrep_sel #(.WAYS(WAYS), .REQS(REQS), .IDX_W(IDX_W)) u_lockrep_sel (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lock(req_lock),
      .req_id(req_id), .req_index(req_index), .way_masks(way_masks),
      .flag_clr(flag_clr), .irq_en_lock(irq_en_lock), .irq_en_evict(irq_en_evict),
      .rsp_valid(rsp_valid), .rsp_way(rsp_way), .err_lock(err_lock),
      .err_evict(err_evict), .irq_lock(irq_lock), .irq_evict(irq_evict));

   // entry: {lock, id[1:0], index[3:0], way[2:0], err_lock, err_evict}
   localparam int NV = 22;
   localparam logic [11:0] VEC [NV] = '{
      {1'b0, 2'd0, 4'd1, 3'd0, 1'b0, 1'b0},  // R3 rotate from 0
      {1'b0, 2'd0, 4'd1, 3'd1, 1'b0, 1'b0},  // R3
      {1'b1, 2'd1, 4'd1, 3'd0, 1'b0, 1'b0},  // R4 wrap, lock granted
      {1'b1, 2'd1, 4'd1, 3'd1, 1'b1, 1'b0},  // R5 last free way refused
      {1'b0, 2'd1, 4'd1, 3'd1, 1'b1, 1'b0},  // R2 skip locked way 0
      {1'b1, 2'd0, 4'd1, 3'd2, 1'b1, 1'b0},  // R4
      {1'b0, 2'd1, 4'd1, 3'd1, 1'b1, 1'b0},  // R5 way 1 stayed unlocked
      {1'b1, 2'd0, 4'd1, 3'd3, 1'b1, 1'b0},  // R2 skip locked 2
      {1'b1, 2'd0, 4'd2, 3'd0, 1'b1, 1'b0},  // R3 own pointer per index
      {1'b1, 2'd0, 4'd2, 3'd1, 1'b1, 1'b0},
      {1'b0, 2'd1, 4'd2, 3'd0, 1'b1, 1'b1},  // R6 forced eviction
      {1'b0, 2'd1, 4'd2, 3'd0, 1'b1, 1'b1},  // R6 way 0 now unlocked
      {1'b1, 2'd2, 4'd2, 3'd4, 1'b1, 1'b1},
      {1'b1, 2'd2, 4'd2, 3'd5, 1'b1, 1'b1},
      {1'b1, 2'd2, 4'd2, 3'd6, 1'b1, 1'b1},
      {1'b1, 2'd2, 4'd2, 3'd7, 1'b1, 1'b1},  // R5 refused
      {1'b0, 2'd2, 4'd2, 3'd7, 1'b1, 1'b1},
      {1'b0, 2'd0, 4'd2, 3'd0, 1'b1, 1'b1},  // R3 pointer wrapped to 0
      {1'b0, 2'd0, 4'd2, 3'd2, 1'b1, 1'b1},
      {1'b0, 2'd3, 4'd2, 3'd0, 1'b1, 1'b1},  // R7 empty mask
      {1'b0, 2'd0, 4'd2, 3'd3, 1'b1, 1'b1},  // R7 pointer untouched
      {1'b0, 2'd0, 4'd2, 3'd7, 1'b1, 1'b1}   // R2 skip 4..6
   };

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic issue(input logic lk, input logic [1:0] id, input logic [3:0] ix,
                        input logic [1:0] clr);
      @(negedge clk);
      req_valid = 1'b1; req_lock = lk; req_id = id; req_index = ix; flag_clr = clr;
      @(negedge clk);
      req_valid = 1'b0; flag_clr = '0;
      check("R10 rsp_valid", int'(rsp_valid), 1);
   endtask

   task automatic pulse_clr(input logic [1:0] clr);
      @(negedge clk); flag_clr = clr;
      @(negedge clk); flag_clr = '0;
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 rsp_valid", int'(rsp_valid), 0);
      check("R1 err_lock", int'(err_lock), 0);
      check("R1 err_evict", int'(err_evict), 0);
      check("R1 irq_lock", int'(irq_lock), 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         issue(VEC[i][11], VEC[i][10:9], VEC[i][8:5], 2'b00);
         check($sformatf("R3 vec%0d way", i), int'(rsp_way), int'(VEC[i][4:2]));
         check($sformatf("R5 vec%0d err_lock", i), int'(err_lock), int'(VEC[i][1]));
         check($sformatf("R6 vec%0d err_evict", i), int'(err_evict), int'(VEC[i][0]));
      end
      @(negedge clk);
      check("R10 idle rsp_valid", int'(rsp_valid), 0);

      // R9 gating
      check("R9 irq_lock enabled", int'(irq_lock), 1);
      check("R9 irq_evict disabled", int'(irq_evict), 0);
      irq_en_evict = 1'b1; #1;
      check("R9 irq_evict enabled", int'(irq_evict), 1);

      // R8 write-1 clear of one flag only
      pulse_clr(2'b01);
      check("R8 lock cleared", int'(err_lock), 0);
      check("R8 evict kept", int'(err_evict), 1);
      check("R9 irq_lock follows", int'(irq_lock), 0);

      // R8 set wins over clear in one cycle (refused lock on index 1 way 1)
      issue(1'b1, 2'd1, 4'd1, 2'b01);
      check("R5 refused way", int'(rsp_way), 1);
      check("R8 set beats clear", int'(err_lock), 1);

      pulse_clr(2'b11);
      check("R8 both cleared lock", int'(err_lock), 0);
      check("R8 both cleared evict", int'(err_evict), 0);

      // R7 empty mask raises nothing
      issue(1'b1, 2'd3, 4'd2, 2'b00);
      check("R7 way", int'(rsp_way), 0);
      check("R7 err_lock", int'(err_lock), 0);
      check("R7 err_evict", int'(err_evict), 0);

      // R6 lock request with every permitted way locked (ways 4..6 locked)
      way_masks[31:24] = 8'h70;
      issue(1'b1, 2'd3, 4'd2, 2'b00);
      check("R6 forced lowest way", int'(rsp_way), 4);
      check("R6 evict flag", int'(err_evict), 1);
      check("R6 lock flag too", int'(err_lock), 1);
      issue(1'b0, 2'd3, 4'd2, 2'b00);
      check("R6 forced way unlocked", int'(rsp_way), 4);

      // R1 reset clears locks and pointers
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R1 flags after reset", int'(err_lock | err_evict), 0);
      check("R1 rsp_valid after reset", int'(rsp_valid), 0);
      rst_n = 1'b1;
      issue(1'b0, 2'd1, 4'd1, 2'b00);
      check("R1 lock bits cleared", int'(rsp_way), 0);
      issue(1'b0, 2'd0, 4'd2, 2'b00);
      check("R1 pointer cleared", int'(rsp_way), 0);

      summary();
   end
endmodule